// File: doc/BRIEF.md
# Jumper-Gated Level-Hold Watchdog

This block is a board watchdog that software controls through one bit of an eight-bit output register on a simple I/O port. The register answers at I/O address 0x437. Bit 6 of the register is a hold level, not a kick code. While that bit reads 1, the timeout counter stays at zero. While it reads 0, the counter advances once per clock. When the counter reaches the programmed timeout, the block drives a reset pulse of fixed width that resets the whole board. To keep the board alive, software sets the bit to 1 and then clears it to 0 again, more often than the timeout period.

A static enable input models a hardware jumper and acts as a second gate. With the jumper off, the counter is cleared and no reset leaves the block, whatever software writes. Taking the jumper away in the middle of a countdown drops the progress made so far. It also cuts short a reset pulse that is already running. The watchdog's own reset pulse also restores the register to its power-on value, in which the hold bit is 1. The watchdog therefore stays quiet until software arms it again. The timeout is a parameter given in clock cycles. Its default is 1.5 s at a 50 MHz clock.

Top module: `gpo_watchdog`

## Requirements
- R1: After `rst_n` is released, `board_rst` is 0 and a read of address 0x437 returns 0x40, so the hold bit (bit 6) is 1 and the watchdog is idle.
- R2: With `io_addr` equal to 0x437, `io_rdata` shows the register contents in the same cycle. A write there with `io_we` high is visible from the following cycle. For any other address, `io_rdata` is 0.
- R3: A write to any address other than 0x437 leaves the register value and the watchdog timing unchanged.
- R4: While bit 6 of the register is 1, `board_rst` never asserts, however long the bit is held.
- R5: With the jumper enabled, a write that clears bit 6 makes `board_rst` rise exactly `TIMEOUT_CYC` clock edges after the edge that took the write.
- R6: Setting bit 6 to 1 and then clearing it again restarts a full countdown of `TIMEOUT_CYC` edges, counted from the edge that clears it.
- R7: Once `board_rst` rises, it stays high for exactly `PULSE_CYC` cycles and then falls.
- R8: The reset pulse returns the register to 0x40. After the pulse, no further reset occurs until software clears bit 6 again.
- R9: While `jumper_en` is 0, `board_rst` stays 0. A single edge with the jumper low clears the countdown. After the jumper returns, a full `TIMEOUT_CYC` edges are needed before a reset.
- R10: Dropping `jumper_en` while a reset pulse is active forces `board_rst` low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| io_addr | input | IO_ADDR_W | I/O address for both reads and writes |
| io_wdata | input | IO_DATA_W | Data to write |
| io_we | input | 1 | Write strobe, sampled at the clock edge |
| io_rdata | output | IO_DATA_W | Register contents when the address matches, otherwise 0 |
| jumper_en | input | 1 | Static hardware enable; 0 disables the watchdog completely |
| board_rst | output | 1 | Board reset pulse, active high |

## Verification
A counter that starts one edge early or late, or that fails to reload on a refresh, moves the rising edge of `board_rst` off its exact slot. That edge is due `TIMEOUT_CYC` edges after the arming write, so such an error shows within one timeout period. A register that is written from the wrong address, or that is not restored by the watchdog's own reset, shows up at once on the 0x437 readback. It also shows within the next timeout as a reset that should not occur. A pulse-width counter that is off by one changes the length of `board_rst` by a cycle. A missing jumper gate shows as a reset pulse while the jumper is low.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   localparam int unsigned IO_ADDR_W = 16;
   localparam int unsigned IO_DATA_W = 8;

   // counter mode, derived each cycle from the enables and the count
   typedef enum logic [1:0] {
      WD_OFF  = 2'd0,
      WD_HELD = 2'd1,
      WD_RUN  = 2'd2,
      WD_FIRE = 2'd3
   } wd_mode_e;

endpackage

// File: rtl/wdt_gpo_reg.sv
module wdt_gpo_reg #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR  = 16'h0437,
   parameter logic [DATA_W-1:0] RESET_VAL = 8'h40,
   parameter int unsigned CTRL_BIT  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              io_we,
   input  logic              sys_rst,
   output logic [DATA_W-1:0] io_rdata,
   output logic              hold_bit
);

   if (CTRL_BIT >= DATA_W) begin : g_bad_bit
      $error("wdt_gpo_reg: CTRL_BIT outside register");
   end
   if (RESET_VAL[CTRL_BIT] != 1'b1) begin : g_bad_rst
      $error("wdt_gpo_reg: reset value must hold the counter");
   end

   logic [DATA_W-1:0] gpo_q;
   logic              hit;

   assign hit = (io_addr == REG_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            gpo_q <= RESET_VAL;
      else if (sys_rst)      gpo_q <= RESET_VAL;
      else if (io_we && hit) gpo_q <= io_wdata;
   end

   assign io_rdata = hit ? gpo_q : '0;
   assign hold_bit = gpo_q[CTRL_BIT];

   // R3
   foreign_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_we && !hit && !sys_rst) |=> $stable(gpo_q));
   // R2
   own_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_we && hit && !sys_rst) |=> (gpo_q == $past(io_wdata)));
   // R8
   sys_rst_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst |=> (gpo_q == RESET_VAL));

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
   import wdt_pkg::*;
#(
   parameter int unsigned TIMEOUT_CYC = 75_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic hold,
   input  logic clear,
   output logic expire
);

   if (TIMEOUT_CYC < 2) begin : g_bad_timeout
      $error("wdt_countdown: TIMEOUT_CYC must be at least 2");
   end

   localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

   logic [CNT_W-1:0] cnt_q;
   wd_mode_e         mode;

   always_comb begin
      if (!enable)             mode = WD_OFF;
      else if (hold || clear)  mode = WD_HELD;
      else if (cnt_q == LAST)  mode = WD_FIRE;
      else                     mode = WD_RUN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else begin
         case (mode)
            WD_RUN:  cnt_q <= cnt_q + 1'b1;
            default: cnt_q <= '0;
         endcase
      end
   end

   assign expire = (mode == WD_FIRE);

   // R5
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == WD_RUN) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
   // R4
   held_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !expire);
   // R9
   off_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !expire);

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
   parameter int unsigned PULSE_CYC = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic abort,
   output logic active
);

   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("wdt_pulse: PULSE_CYC must be at least 1");
   end

   if (PULSE_CYC == 1) begin : g_single
      logic act_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) act_q <= 1'b0;
         else        act_q <= fire && !abort;
      end
      assign active = act_q;
   end else begin : g_counted
      localparam int unsigned PW = $clog2(PULSE_CYC + 1);
      logic [PW-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 left_q <= '0;
         else if (abort)             left_q <= '0;
         else if (fire)              left_q <= PW'(PULSE_CYC);
         else if (left_q != '0)      left_q <= left_q - 1'b1;
      end
      assign active = (left_q != '0);

      // R7
      pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || abort)
         $rose(active) |=> active);
   end

   // R10
   abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !active);

endmodule

// File: rtl/gpo_watchdog.sv
module gpo_watchdog
   import wdt_pkg::*;
#(
   parameter int unsigned IO_ADDR_W   = wdt_pkg::IO_ADDR_W,
   parameter int unsigned IO_DATA_W   = wdt_pkg::IO_DATA_W,
   parameter logic [IO_ADDR_W-1:0] WDT_ADDR  = 16'h0437,
   parameter logic [IO_DATA_W-1:0] REG_RESET = 8'h40,
   parameter int unsigned CTRL_BIT    = 6,
   parameter int unsigned CLK_HZ      = 50_000_000,
   parameter int unsigned TIMEOUT_CYC = (CLK_HZ / 2) * 3,
   parameter int unsigned PULSE_CYC   = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IO_ADDR_W-1:0] io_addr,
   input  logic [IO_DATA_W-1:0] io_wdata,
   input  logic                 io_we,
   output logic [IO_DATA_W-1:0] io_rdata,
   input  logic                 jumper_en,
   output logic                 board_rst
);

   logic hold_bit;
   logic expire;
   logic pulse_active;

   wdt_gpo_reg #(
      .ADDR_W    (IO_ADDR_W),
      .DATA_W    (IO_DATA_W),
      .REG_ADDR  (WDT_ADDR),
      .RESET_VAL (REG_RESET),
      .CTRL_BIT  (CTRL_BIT)
   ) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .io_addr  (io_addr),
      .io_wdata (io_wdata),
      .io_we    (io_we),
      .sys_rst  (board_rst),
      .io_rdata (io_rdata),
      .hold_bit (hold_bit)
   );

   wdt_countdown #(
      .TIMEOUT_CYC (TIMEOUT_CYC)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (jumper_en),
      .hold   (hold_bit),
      .clear  (pulse_active),
      .expire (expire)
   );

   wdt_pulse #(
      .PULSE_CYC (PULSE_CYC)
   ) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (expire),
      .abort  (!jumper_en),
      .active (pulse_active)
   );

   assign board_rst = pulse_active && jumper_en;

   // R5
   rise_needs_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_active) |-> $past(expire));

endmodule

// File: tb/gpo_watchdog_tb.sv
module gpo_watchdog_tb;

   localparam int T = 20;
   localparam int P = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] io_addr;
   logic [7:0]  io_wdata;
   logic        io_we;
   logic [7:0]  io_rdata;
   logic        jumper_en;
   logic        board_rst;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   gpo_watchdog #(
      .TIMEOUT_CYC (T),
      .PULSE_CYC   (P)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .io_addr   (io_addr),
      .io_wdata  (io_wdata),
      .io_we     (io_we),
      .io_rdata  (io_rdata),
      .jumper_en (jumper_en),
      .board_rst (board_rst)
   );

   // {we, waddr, wdata, raddr, expected rdata}
   localparam logic [48:0] VEC [8] = '{
      {1'b1, 16'h0437, 8'hC5, 16'h0437, 8'hC5},
      {1'b1, 16'h0436, 8'h00, 16'h0437, 8'hC5},
      {1'b1, 16'h0537, 8'h00, 16'h0437, 8'hC5},
      {1'b0, 16'h0437, 8'h00, 16'h0436, 8'h00},
      {1'b1, 16'h0437, 8'h7F, 16'h0437, 8'h7F},
      {1'b1, 16'h1437, 8'h00, 16'h0437, 8'h7F},
      {1'b1, 16'h0438, 8'h00, 16'h0438, 8'h00},
      {1'b1, 16'h0437, 8'h40, 16'h0437, 8'h40}
   };

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      io_addr  = a;
      io_wdata = d;
      io_we    = 1'b1;
      tick(1);
      io_we    = 1'b0;
      io_addr  = 16'h0437;
      #1;
   endtask

   task automatic rst_is(input logic v, input string req);
      chk(board_rst == v, req, {15'd0, board_rst}, {15'd0, v});
   endtask

   task automatic quiet_for(input int n, input string req);
      int seen = 0;
      for (int k = 0; k < n; k++) begin
         tick(1);
         if (board_rst) seen++;
      end
      chk(seen == 0, req, 16'(seen), 16'd0);
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired: actual 0 expected 1");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; jumper_en = 1'b1; io_we = 1'b0;
      io_addr = 16'h0437; io_wdata = 8'h00;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      rst_is(1'b0, "R1 board_rst after reset");
      chk(io_rdata == 8'h40, "R1 register after reset", {8'd0, io_rdata}, 16'h0040);

      // table walk: R2 readback, R3 foreign writes, R4 hold bit kept at 1
      foreach (VEC[i]) begin
         io_we    = VEC[i][48];
         io_addr  = VEC[i][47:32];
         io_wdata = VEC[i][31:24];
         tick(1);
         io_we    = 1'b0;
         io_addr  = VEC[i][23:8];
         #1;
         chk(io_rdata == VEC[i][7:0], "R2/R3 readback", {8'd0, io_rdata}, {8'd0, VEC[i][7:0]});
         rst_is(1'b0, "R4 no reset while held");
      end

      // R4 long hold
      quiet_for(3 * T, "R4 long hold");

      // R5 timeout, R7 pulse width, R8 self-restore
      wr(16'h0437, 8'h00);
      tick(T - 1);
      rst_is(1'b0, "R5 before timeout");
      tick(1);
      rst_is(1'b1, "R5 at timeout");
      tick(P - 1);
      rst_is(1'b1, "R7 pulse last cycle");
      tick(1);
      rst_is(1'b0, "R7 pulse end");
      chk(io_rdata == 8'h40, "R8 register restored", {8'd0, io_rdata}, 16'h0040);
      quiet_for(3 * T, "R8 idle after pulse");

      // R6 refresh restarts the countdown
      wr(16'h0437, 8'h00);
      tick(T - 3);
      wr(16'h0437, 8'h40);
      wr(16'h0437, 8'h00);
      tick(T - 1);
      rst_is(1'b0, "R6 refreshed, not yet");
      tick(1);
      rst_is(1'b1, "R6 full period after refresh");
      tick(P);

      // R9 jumper off: armed bit has no effect
      jumper_en = 1'b0;
      wr(16'h0437, 8'h00);
      quiet_for(3 * T, "R9 jumper off");
      jumper_en = 1'b1;
      #1;
      tick(T - 1);
      rst_is(1'b0, "R9 count from jumper on");
      tick(1);
      rst_is(1'b1, "R9 timeout after jumper on");

      // R10 jumper drop aborts active pulse
      jumper_en = 1'b0;
      #1;
      rst_is(1'b0, "R10 abort same cycle");
      quiet_for(2 * T, "R10 stays off");
      wr(16'h0437, 8'h40);
      jumper_en = 1'b1;

      // R9 mid-count cancel
      wr(16'h0437, 8'h00);
      tick(T - 4);
      jumper_en = 1'b0;
      tick(1);
      jumper_en = 1'b1;
      #1;
      tick(T - 1);
      rst_is(1'b0, "R9 cancel cleared count");
      tick(1);
      rst_is(1'b1, "R5 timeout after cancel");
      tick(P);

      // R1 power-on reset mid-count
      wr(16'h0437, 8'h00);
      tick(5);
      rst_n = 1'b0;
      tick(1);
      rst_is(1'b0, "R1 during reset");
      rst_n = 1'b1;
      tick(1);
      chk(io_rdata == 8'h40, "R1 register after mid-count reset", {8'd0, io_rdata}, 16'h0040);
      quiet_for(2 * T, "R1 idle after reset");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule